// File: doc/BRIEF.md
# Multi-Register Transfer Address Sequencer

This block turns one load/store-multiple operation into a stream of single-word memory requests. A start strobe hands it a base address, a 16-bit register selection mask and three control bits: direction (up or down), pre/post adjustment, and writeback. It then issues one request for each selected register, always from the lowest register index to the highest. Each request carries the register index, the word address and the load/store flag, and it advances on a valid/ready handshake.

The addresses are laid out so that the lowest-numbered register always sits at the lowest address in every mode. In a decrementing mode the block therefore computes the bottom of the block first and walks upward through it. After the last transfer it raises a one-cycle done pulse. With that pulse it gives the adjusted base value and a flag that says whether the base should be written back. Moving the data, choosing banked registers and restoring status are left to other logic.

Top module: `blk_xfer_seq`

## Requirements
- R1: After an accepted start, the block issues exactly one request for each set bit of the mask. Requests come in strictly ascending register index order, and req_reg_o carries the bit position.
- R2: With n set bits, the first address depends on the mode. For up with pre, it is base+4. For up with post, it is base. For down with pre, it is base−4n. For down with post, it is base−4n+4. Each later request is 4 above the previous one.
- R3: The value on wb_val_o during done is base+4n when the direction is up and base−4n when it is down.
- R4: An empty mask produces no request. done_o rises in the cycle after the start, with wb_val_o equal to the base.
- R5: While req_valid_o is high and req_ready_i is low, the index, address and load flag hold steady.
- R6: done_o is a single-cycle pulse. It rises in the cycle after the final handshake and never coincides with req_valid_o.
- R7: A start strobe that arrives while busy_o is high has no effect on the request sequence in progress or on its result.
- R8: After reset, req_valid_o, done_o, wb_en_o and busy_o are low.
- R9: req_load_o equals the load bit given at start for every request of the operation. wb_en_o equals the writeback bit given at start while done_o is high, and it is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts an operation when idle |
| base_i | input | 32 | Base address |
| list_i | input | 16 | Register selection mask, bit k selects register k |
| pre_i | input | 1 | 1: adjust before each transfer, 0: after |
| up_i | input | 1 | 1: increment by 4, 0: decrement by 4 |
| wb_i | input | 1 | Request base writeback |
| load_i | input | 1 | 1: load, 0: store |
| busy_o | output | 1 | Operation in progress |
| req_valid_o | output | 1 | Request present |
| req_ready_i | input | 1 | Request accepted when high with valid |
| req_reg_o | output | 4 | Register index of the request |
| req_addr_o | output | 32 | Word address of the request |
| req_load_o | output | 1 | Load/store flag of the request |
| done_o | output | 1 | One-cycle completion pulse |
| wb_en_o | output | 1 | Writeback requested, valid with done_o |
| wb_val_o | output | 32 | Adjusted base value |

## Verification
The hardest situation to reach from the ports is a new start strobe arriving while a sequence is stalled mid-stream. Both the ignore path and the hold path are exercised only if the strobe lands while requests are still outstanding. The bench therefore injects a start with different fields a cycle after the first request, while holding ready low at random. Decrementing modes with a base just above zero force the start address to wrap, which checks the arithmetic at the ends of the address range.

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int ADDR_W = 32,
  parameter int LIST_W = 16,
  parameter int STEP   = 4,
  localparam int IDX_W = $clog2(LIST_W),
  localparam int CNT_W = $clog2(LIST_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LIST_W-1:0] list_i,
  input  logic              pre_i,
  input  logic              up_i,
  input  logic              wb_i,
  input  logic              load_i,
  output logic              busy_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [IDX_W-1:0]  req_reg_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              req_load_o,
  output logic              done_o,
  output logic              wb_en_o,
  output logic [ADDR_W-1:0] wb_val_o
);
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;

  function automatic logic [CNT_W-1:0] pop(input logic [LIST_W-1:0] v);
    logic [CNT_W-1:0] c = '0;
    for (int i = 0; i < LIST_W; i++) c += CNT_W'(v[i]);
    return c;
  endfunction

  function automatic logic [IDX_W-1:0] low_idx(input logic [LIST_W-1:0] v);
    logic [IDX_W-1:0] r = '0;
    for (int i = LIST_W - 1; i >= 0; i--) if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  st_t               st;
  logic [LIST_W-1:0] rem;
  logic [ADDR_W-1:0] addr, wbv;
  logic              wbf, ld;

  logic [ADDR_W-1:0] span, first_addr, wb_next;
  logic [LIST_W-1:0] rem_next;

  assign span       = ADDR_W'(pop(list_i)) * STEP_A;
  assign first_addr = up_i ? base_i + (pre_i ? STEP_A : '0)
                           : base_i - span + (pre_i ? '0 : STEP_A);
  assign wb_next    = up_i ? base_i + span : base_i - span;
  assign rem_next   = rem & (rem - LIST_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      rem  <= '0;
      addr <= '0;
      wbv  <= '0;
      wbf  <= 1'b0;
      ld   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          rem  <= list_i;
          addr <= first_addr;
          wbv  <= wb_next;
          wbf  <= wb_i;
          ld   <= load_i;
          st   <= (list_i == '0) ? S_FIN : S_RUN;
        end
        S_RUN: if (req_ready_i) begin
          rem  <= rem_next;
          addr <= addr + STEP_A;
          if (rem_next == '0) st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (st != S_IDLE);
  assign req_valid_o = (st == S_RUN);
  assign req_reg_o   = low_idx(rem);
  assign req_addr_o  = addr;
  assign req_load_o  = ld;
  assign done_o      = (st == S_FIN);
  assign wb_en_o     = done_o & wbf;
  assign wb_val_o    = wbv;
endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int LIST_W = 16,
  parameter int STEP   = 4,
  localparam int IDX_W = $clog2(LIST_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [ADDR_W-1:0] base_i,
  input logic [LIST_W-1:0] list_i,
  input logic              up_i,
  input logic              busy_o,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [IDX_W-1:0]  req_reg_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic              req_load_o,
  input logic              done_o,
  input logic              wb_en_o,
  input logic [ADDR_W-1:0] wb_val_o
);
  // R1
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && req_ready_i |=> done_o || req_reg_o > $past(req_reg_o));
  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && req_ready_i |=> done_o || req_addr_o == $past(req_addr_o) + ADDR_W'(STEP));
  // R3
  wb_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start_i |=> wb_val_o == ($past(up_i)
      ? $past(base_i) + ADDR_W'($countones($past(list_i)) * STEP)
      : $past(base_i) - ADDR_W'($countones($past(list_i)) * STEP)));
  // R4
  empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start_i && list_i == '0 |=> done_o && !req_valid_o && wb_val_o == $past(base_i));
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_reg_o) && $stable(req_load_o));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R6
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && req_valid_o));
  // R8
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o || done_o |-> busy_o);
  // R9
  wb_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |-> done_o);
endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.ADDR_W(ADDR_W), .LIST_W(LIST_W), .STEP(STEP)) u_chk (.*);

// File: tb/blk_xfer_seq_tb.sv
module blk_xfer_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start_i = 1'b0, pre_i = 1'b0, up_i = 1'b0, wb_i = 1'b0, load_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] list_i = '0;
  logic        req_ready_i = 1'b0;
  logic        busy_o, req_valid_o, req_load_o, done_o, wb_en_o;
  logic [3:0]  req_reg_o;
  logic [31:0] req_addr_o, wb_val_o;

  int tests = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_xfer_seq u_dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // Reference: behavioural address list and result
  task automatic run_op(input logic [31:0] base, input logic [15:0] list,
                        input bit pre, input bit up, input bit wb, input bit ld,
                        input int ready_pct, input bit intrude);
    int          idx[$];
    logic [31:0] lo, wbexp;
    int          n, k = 0, guard = 0;
    bit          hs, seen_done = 0;
    for (int i = 0; i < 16; i++) if (list[i]) idx.push_back(i);
    n = idx.size();
    lo    = up ? base + (pre ? 32'd4 : 32'd0) : base - 32'(4*n) + (pre ? 32'd0 : 32'd4);
    wbexp = up ? base + 32'(4*n) : base - 32'(4*n);
    @(negedge clk);
    start_i = 1; base_i = base; list_i = list; pre_i = pre; up_i = up; wb_i = wb; load_i = ld;
    @(negedge clk);
    start_i = 0;
    while (!seen_done && guard < 2000) begin
      guard++;
      if (k < n) begin
        chk(req_valid_o === 1'b1 && done_o === 1'b0, "R1", "valid while pending", req_valid_o, 1);
        chk(req_reg_o == 4'(idx[k]), "R1", "register index", req_reg_o, idx[k]);
        chk(req_addr_o == lo + 32'(4*k), "R2", "address", req_addr_o, lo + 32'(4*k));
        chk(req_load_o == ld, "R9", "load flag", req_load_o, ld);
      end else begin
        chk(done_o === 1'b1 && req_valid_o === 1'b0, (n == 0) ? "R4" : "R6", "done after last", done_o, 1);
        chk(wb_val_o == wbexp, (n == 0) ? "R4" : "R3", "writeback value", wb_val_o, wbexp);
        chk(wb_en_o == wb, "R9", "writeback enable", wb_en_o, wb);
        seen_done = 1;
      end
      if (seen_done) break;
      req_ready_i = ($urandom_range(99) < ready_pct);
      if (intrude && k == 0 && guard == 1) begin
        // R7: foreign start while busy
        start_i = 1; base_i = ~base; list_i = ~list; up_i = ~up; pre_i = ~pre; load_i = ~ld; wb_i = ~wb;
      end else start_i = 0;
      hs = req_valid_o && req_ready_i;
      @(negedge clk);
      if (hs) k++;
    end
    start_i = 0;
    req_ready_i = 0;
    chk(seen_done, "R6", "done seen", seen_done, 1);
    @(negedge clk);
    chk(done_o === 1'b0 && busy_o === 1'b0 && wb_en_o === 1'b0, "R6", "done single pulse", done_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8
    chk(req_valid_o === 1'b0 && done_o === 1'b0 && busy_o === 1'b0 && wb_en_o === 1'b0,
        "R8", "reset outputs", {req_valid_o, done_o, busy_o, wb_en_o}, 0);
    rst_n = 1;
    for (int m = 0; m < 4; m++) begin
      run_op(32'h0000_1000, 16'h0000, m[1], m[0], 1, 0, 100, 0);          // R4
      run_op(32'h0000_2000, 16'hFFFF, m[1], m[0], 1, 1, 100, 0);          // R2 full
      run_op(32'h0000_3000, 16'h8000, m[1], m[0], 0, 0, 50, 0);           // single top bit
      run_op(32'h0000_0004, 16'h0007, m[1], m[0], 1, 1, 70, 0);           // wrap near zero
      for (int r = 0; r < 6; r++)
        run_op($urandom, 16'($urandom), m[1], m[0], r[0], r[1], 60, 0);  // R1 R2 R3 random
      run_op(32'h0001_0000, 16'h0A51, m[1], m[0], 1, 0, 30, 1);          // R5 R7
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule